// File: doc/BRIEF.md
# I2C Target with Charge-Control Register

This block is a serial bus target that lets an I2C controller reach a small file of byte registers through a register pointer. SCL and SDA are brought into the system clock domain through synchronizers and examined for edges there. As a result the system clock, not SCL, times every state change, and the system clock has to run at least 8 times faster than a 400 kHz SCL. The target answers only to the 7-bit address 1101000. In a write transfer, the byte after the address loads the pointer and any later bytes are stored. A read transfer returns bytes starting at the current pointer.

One register in the file, at index `CHG_IDX`, controls an external charging network. Its byte is decoded into registered outputs: a charger enable, a diode enable and a one-hot resistor select. The charger is turned on only when the upper nibble holds the key 1010 and both select fields hold legal codes. Every other value leaves all the decoded outputs at zero. The block drives SDA as an open-drain line. It has a single pull-low enable, and the pin and its pull-up are outside the block.

Top module: `chg_i2c_target`

## Requirements
- R1: A transfer begins only on a START, which is SDA falling while SCL is high. A STOP, which is SDA rising while SCL is high, returns the target to idle. A byte clocked in while idle is not acknowledged.
- R2: The first byte after a START is acknowledged, with SDA low on the ninth clock, only when its upper 7 bits equal 1101000. Bit 0 is the direction bit, where 0 means write and 1 means read. On a mismatch the target leaves SDA released until the next START.
- R3: In a write transfer, the byte after the address loads the pointer with the word address modulo the register count. Each later byte is stored at the pointer. The target acknowledges both the word address and every data byte.
- R4: The pointer advances by one after each data byte written or read, and it wraps from the last index to 0. A read that starts without a word address begins at the current pointer.
- R5: In a read transfer, the target shifts out the byte at the pointer, most significant bit first. A controller acknowledge, SDA low on the ninth clock, makes it send the next byte. A not-acknowledge makes it leave SDA released until the next START.
- R6: A repeated START ends the current transfer and begins address reception without a STOP in between.
- R7: After reset the charge-control register holds 0x00, and chg_en, diode_on, res_sel and sda_oe are all 0.
- R8: chg_en is 1 only when bits 7:4 of the charge-control register equal 1010 and the select fields are legal. Any other key value forces chg_en, diode_on and res_sel to 0.
- R9: Bits 3:2 select the diode: 01 gives no diode (diode_on=0) and 10 gives one diode (diode_on=1). The codes 00 and 11 force all decoded outputs to 0.
- R10: Bits 1:0 select the resistor: 01 gives res_sel=001 (low), 10 gives 010 (middle) and 11 gives 100 (high). The code 00 forces all decoded outputs to 0. When chg_en is 1, res_sel is one-hot.
- R11: SDA is only ever pulled low or released, and sda_oe does not change while SCL is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| chg_en | output | 1 | Charger enable |
| diode_on | output | 1 | Series diode select |
| res_sel | output | 3 | One-hot resistor select: bit 0 low, bit 1 middle, bit 2 high |

## Verification
A wrong pointer or bit count inside the target appears at the ports within one byte time. It shows either as a read byte that differs from the bench's model or as an acknowledge that is missing or comes when none should. A corrupted charge-control byte reaches the three decoded outputs within two system clocks of the write, so the decoded outputs are checked shortly after every STOP. A state machine that fails to return to idle shows as an acknowledge to a wrong address, or as SDA held low after a not-acknowledge, which the bench samples on the very next clock.

// File: rtl/chg_i2c_pkg.sv
package chg_i2c_pkg;
  localparam logic [3:0] CHG_KEY    = 4'b1010;
  localparam logic [1:0] DIODE_NONE = 2'b01;
  localparam logic [1:0] DIODE_ONE  = 2'b10;
  localparam int         RES_CODES  = 3;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_RD_NEXT
  } tgt_state_t;

  typedef struct packed {
    logic [3:0] key;
    logic [1:0] diode;
    logic [1:0] res;
  } chg_ctrl_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic line_s,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '1;
    else     pipe <= {pipe[STAGES-1:0], line_i};
  end

  assign line_s = pipe[STAGES-1];
  assign rise   = pipe[STAGES-1] & ~pipe[STAGES];
  assign fall   = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import chg_i2c_pkg::*;
#(
  parameter logic [6:0] ADDR7    = 7'b1101000,
  parameter int         NUM_REGS = 8,
  parameter int         PW       = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_s,
  input  logic          sda_rise,
  input  logic          sda_fall,
  input  logic [7:0]    rd_data,
  output logic          sda_oe,
  output logic [PW-1:0] ptr,
  output logic          wr_en,
  output logic [PW-1:0] wr_addr,
  output logic [7:0]    wr_data
);
  localparam logic [PW-1:0] LAST = PW'(NUM_REGS - 1);

  tgt_state_t    state;
  logic [3:0]    bit_cnt;
  logic [7:0]    sh;
  logic          rw;
  logic          start_cond;
  logic          stop_cond;
  logic [PW-1:0] ptr_next;

  assign start_cond = scl_s & sda_fall;
  assign stop_cond  = scl_s & sda_rise;
  assign ptr_next   = (ptr == LAST) ? '0 : ptr + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      sh      <= '0;
      rw      <= 1'b0;
      sda_oe  <= 1'b0;
      ptr     <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_cond) begin
        state   <= ST_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_cond) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_PTR, ST_WR: begin
            if (scl_rise && bit_cnt != 4'd8) begin
              sh      <= {sh[6:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              bit_cnt <= '0;
              if (state == ST_ADDR) begin
                if (sh[7:1] == ADDR7) begin
                  rw     <= sh[0];
                  sda_oe <= 1'b1;
                  state  <= ST_ADDR_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_PTR) begin
                ptr    <= sh[PW-1:0];
                sda_oe <= 1'b1;
                state  <= ST_PTR_ACK;
              end else begin
                wr_en   <= 1'b1;
                wr_addr <= ptr;
                wr_data <= sh;
                ptr     <= ptr_next;
                sda_oe  <= 1'b1;
                state   <= ST_WR_ACK;
              end
            end
          end
          ST_ADDR_ACK, ST_PTR_ACK, ST_WR_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              if (state == ST_ADDR_ACK && rw) begin
                sh      <= rd_data;
                sda_oe  <= ~rd_data[7];
                bit_cnt <= 4'd1;
                state   <= ST_RD;
              end else if (state == ST_ADDR_ACK) begin
                state <= ST_PTR;
              end else begin
                state <= ST_WR;
              end
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (bit_cnt == 4'd8) begin
                sda_oe <= 1'b0;
                state  <= ST_RD_ACK;
              end else begin
                sda_oe  <= ~sh[6];
                sh      <= {sh[6:0], 1'b0};
                bit_cnt <= bit_cnt + 4'd1;
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              ptr   <= ptr_next;
              state <= sda_s ? ST_IDLE : ST_RD_NEXT;
            end
          end
          ST_RD_NEXT: begin
            if (scl_fall) begin
              sh      <= rd_data;
              sda_oe  <= ~rd_data[7];
              bit_cnt <= 4'd1;
              state   <= ST_RD;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/chg_regfile.sv
module chg_regfile
  import chg_i2c_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int PW       = 3,
  parameter int CHG_IDX  = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [PW-1:0]        wr_addr,
  input  logic [7:0]           wr_data,
  input  logic [PW-1:0]        rd_addr,
  output logic [7:0]           rd_data,
  output logic                 chg_en,
  output logic                 diode_on,
  output logic [RES_CODES-1:0] res_sel
);
  localparam logic [PW-1:0] CHG_ADDR = PW'(CHG_IDX);

  logic [7:0]    mem [NUM_REGS];
  logic [7:0]    rd_q;
  logic [PW-1:0] rd_addr_q;
  logic [7:0]    chg_reg;
  chg_ctrl_t     fld;
  logic          valid;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_q      <= mem[rd_addr];
    rd_addr_q <= rd_addr;
  end

  always_ff @(posedge clk) begin
    if (rst)                                chg_reg <= 8'h00;
    else if (wr_en && wr_addr == CHG_ADDR)  chg_reg <= wr_data;
  end

  assign rd_data = (rd_addr_q == CHG_ADDR) ? chg_reg : rd_q;

  assign fld   = chg_ctrl_t'(chg_reg);
  assign valid = (fld.key == CHG_KEY) &&
                 (fld.diode == DIODE_NONE || fld.diode == DIODE_ONE) &&
                 (fld.res != 2'b00);

  always_ff @(posedge clk) begin
    if (rst) begin
      chg_en   <= 1'b0;
      diode_on <= 1'b0;
    end else begin
      chg_en   <= valid;
      diode_on <= valid && (fld.diode == DIODE_ONE);
    end
  end

  for (genvar g = 0; g < RES_CODES; g++) begin : g_res
    always_ff @(posedge clk) begin
      if (rst) res_sel[g] <= 1'b0;
      else     res_sel[g] <= valid && (fld.res == 2'(g + 1));
    end
  end
endmodule

// File: rtl/chg_i2c_target.sv
module chg_i2c_target
  import chg_i2c_pkg::*;
#(
  parameter logic [6:0] ADDR7    = 7'b1101000,
  parameter int         NUM_REGS = 8,
  parameter int         CHG_IDX  = 3,
  parameter int         SYNC_STG = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_oe,
  output logic                 chg_en,
  output logic                 diode_on,
  output logic [RES_CODES-1:0] res_sel
);
  localparam int PW = $clog2(NUM_REGS);

  logic          scl_s, scl_rise, scl_fall;
  logic          sda_s, sda_rise, sda_fall;
  logic [PW-1:0] ptr, wr_addr;
  logic          wr_en;
  logic [7:0]    wr_data, rd_data;

  i2c_line_sync #(.STAGES(SYNC_STG)) i_scl_sync (
    .clk(clk), .rst(rst), .line_i(scl_i),
    .line_s(scl_s), .rise(scl_rise), .fall(scl_fall)
  );

  i2c_line_sync #(.STAGES(SYNC_STG)) i_sda_sync (
    .clk(clk), .rst(rst), .line_i(sda_i),
    .line_s(sda_s), .rise(sda_rise), .fall(sda_fall)
  );

  i2c_target_fsm #(.ADDR7(ADDR7), .NUM_REGS(NUM_REGS), .PW(PW)) i_fsm (
    .clk(clk), .rst(rst),
    .scl_s(scl_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(sda_s), .sda_rise(sda_rise), .sda_fall(sda_fall),
    .rd_data(rd_data), .sda_oe(sda_oe), .ptr(ptr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  chg_regfile #(.NUM_REGS(NUM_REGS), .PW(PW), .CHG_IDX(CHG_IDX)) i_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(ptr), .rd_data(rd_data),
    .chg_en(chg_en), .diode_on(diode_on), .res_sel(res_sel)
  );
endmodule

// File: rtl/chg_i2c_chk.sv
module chg_i2c_chk (
  input logic       clk,
  input logic       rst,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       chg_en,
  input logic       diode_on,
  input logic [2:0] res_sel
);
  // R7
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!chg_en && !diode_on && res_sel == 3'b000 && !sda_oe));

  // R8
  off_outputs_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !chg_en |-> (!diode_on && res_sel == 3'b000));

  // R10
  res_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    chg_en |-> ($countones(res_sel) == 1));

  // R11
  sda_stable_high_chk: assert property (@(posedge clk) disable iff (rst)
    (scl_i && $past(scl_i) && $past(scl_i, 2) && $past(scl_i, 3)) |-> $stable(sda_oe));
endmodule

bind chg_i2c_target chg_i2c_chk i_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe),
  .chg_en(chg_en), .diode_on(diode_on), .res_sel(res_sel)
);

// File: tb/test_chg_i2c_target.sv
module test_chg_i2c_target;
  localparam int Q   = 40;
  localparam int NR  = 8;
  localparam int CIX = 3;
  localparam logic [6:0] TADDR = 7'b1101000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_bus;
  logic sda_oe, chg_en, diode_on;
  logic [2:0] res_sel;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [7:0] model [NR];
  logic [7:0] wbuf [16];
  int mptr = 0;

  always #2 clk = ~clk;
  assign sda_bus = m_sda & ~sda_oe;

  chg_i2c_target i_chg_i2c_target (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .chg_en(chg_en), .diode_on(diode_on), .res_sel(res_sel)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  function automatic logic [4:0] exp_dec(input logic [7:0] b);
    logic v;
    v = (b[7:4] == 4'b1010) && (b[3:2] == 2'b01 || b[3:2] == 2'b10) && (b[1:0] != 2'b00);
    return {v, v && (b[3:2] == 2'b10), v ? (3'b001 << (b[1:0] - 2'd1)) : 3'b000};
  endfunction

  task automatic bus_start();
    m_sda = 1; scl = 1; #Q; m_sda = 0; #Q; scl = 0; #Q;
  endtask

  task automatic bus_rstart();
    m_sda = 1; #Q; scl = 1; #Q; m_sda = 0; #Q; scl = 0; #Q;
  endtask

  task automatic bus_stop();
    m_sda = 0; #Q; scl = 1; #Q; m_sda = 1; #Q;
  endtask

  task automatic bit_io(input logic d, output logic s);
    m_sda = d; #Q; scl = 1; #Q; s = sda_bus; #Q; scl = 0; #Q;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(b[i], s);
    bit_io(1'b1, ack);
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    logic s;
    b = 8'h00;
    for (int i = 0; i < 8; i++) begin
      bit_io(1'b1, s);
      b = {b[6:0], s};
    end
    bit_io(nack, s);
  endtask

  task automatic check_outputs(input string tag);
    logic [4:0] e;
    #(10 * 4);
    e = exp_dec(model[CIX]);
    check(tag, {27'd0, chg_en, diode_on, res_sel}, {27'd0, e});
  endtask

  task automatic do_write(input int wa, input int n);
    logic ack;
    bus_start();
    send_byte({TADDR, 1'b0}, ack);
    check("R2 address ack on write", ack, 0);
    send_byte(8'(wa), ack);
    check("R3 word address ack", ack, 0);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack);
      check("R3 data byte ack", ack, 0);
      model[(wa + i) % NR] = wbuf[i];
    end
    bus_stop();
    mptr = (wa + n) % NR;
  endtask

  task automatic do_read(input int wa, input bit set_ptr, input int n);
    logic ack;
    logic [7:0] b;
    bus_start();
    if (set_ptr) begin
      send_byte({TADDR, 1'b0}, ack);
      check("R2 address ack before word address", ack, 0);
      send_byte(8'(wa), ack);
      check("R3 word address ack before read", ack, 0);
      bus_rstart();
      mptr = wa % NR;
    end
    send_byte({TADDR, 1'b1}, ack);
    check(set_ptr ? "R6 address ack after repeated start" : "R2 address ack on read", ack, 0);
    for (int i = 0; i < n; i++) begin
      recv_byte(i == n - 1, b);
      check("R5 R4 read data at pointer", b, model[mptr]);
      mptr = (mptr + 1) % NR;
    end
    #Q;
    check("R5 SDA released after not-acknowledge", sda_bus, 1);
    bus_stop();
  endtask

  initial begin
    #(190000 * 4);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] vec [12];
    void'($urandom(32'd2024));
    #1;
    #(10 * 4);
    rst = 0;
    #(10 * 4);
    // R7 reset state
    check("R7 reset decoded outputs", {chg_en, diode_on, res_sel}, 5'b0);
    check("R7 reset sda_oe", sda_oe, 0);
    for (int i = 0; i < NR; i++) model[i] = 8'h00;

    // fill the file; charge register stays 0x00
    for (int i = 0; i < NR; i++) wbuf[i] = 8'($urandom);
    wbuf[CIX] = 8'h00;
    do_write(0, NR);
    check_outputs("R7 R8 outputs after zero charge byte");
    do_read(0, 1, NR);

    // wrap of pointer on write and read
    for (int i = 0; i < 4; i++) wbuf[i] = 8'($urandom);
    wbuf[1] = 8'h11; wbuf[2] = 8'h22;
    do_write(6, 4);
    check("R4 pointer wrapped after write", mptr, 2);
    do_read(6, 1, 4);
    do_read(0, 0, 2);

    // word address only, then current-pointer read
    bus_start();
    send_byte({TADDR, 1'b0}, ack);
    send_byte(8'(5), ack);
    check("R3 word address alone acked", ack, 0);
    bus_stop();
    mptr = 5;
    do_read(0, 0, 1);

    // charge-control decode table
    vec[0] = 8'hA5; vec[1] = 8'hA9; vec[2] = 8'hA6; vec[3] = 8'hAA;
    vec[4] = 8'hA7; vec[5] = 8'hAB; vec[6] = 8'hA4; vec[7] = 8'hA1;
    vec[8] = 8'hAD; vec[9] = 8'hB5; vec[10] = 8'h25; vec[11] = 8'h5A;
    for (int i = 0; i < 12; i++) begin
      wbuf[0] = vec[i];
      do_write(CIX, 1);
      check_outputs("R8/R9/R10 decode of charge byte");
    end

    // enable, then wrong address must not touch it
    wbuf[0] = 8'hAB;
    do_write(CIX, 1);
    check_outputs("R10 high resistor with diode");
    bus_start();
    send_byte({7'b1101001, 1'b0}, ack);
    check("R2 wrong address not acked", ack, 1);
    send_byte(8'(CIX), ack);
    check("R2 byte after wrong address not acked", ack, 1);
    send_byte(8'h00, ack);
    check("R2 data after wrong address not acked", ack, 1);
    bus_stop();
    check_outputs("R2 wrong address left charge byte");
    do_read(0, 0, 1);

    // byte with no START is ignored
    send_byte({TADDR, 1'b0}, ack);
    check("R1 byte without start not acked", ack, 1);
    send_byte(8'(CIX), ack);
    send_byte(8'h00, ack);
    check("R1 idle data not acked", ack, 1);
    bus_stop();
    check_outputs("R1 idle bytes left charge byte");

    // repeated start during a write begins a new transfer
    bus_start();
    send_byte({TADDR, 1'b0}, ack);
    send_byte(8'(CIX), ack);
    bus_rstart();
    send_byte({TADDR, 1'b0}, ack);
    check("R6 repeated start address ack", ack, 0);
    send_byte(8'(CIX), ack);
    send_byte(8'hA6, ack);
    check("R6 data ack in new transfer", ack, 0);
    bus_stop();
    model[CIX] = 8'hA6;
    mptr = (CIX + 1) % NR;
    check_outputs("R6 write after repeated start");

    // random mix
    for (int it = 0; it < 24; it++) begin
      int op;
      op = int'($urandom % 3);
      if (op == 0) begin
        wbuf[0] = 8'($urandom);
        if ($urandom % 2 == 0) wbuf[0][7:4] = 4'b1010;
        do_write(CIX, 1);
        check_outputs("R8/R9/R10 random charge byte");
      end else if (op == 1) begin
        int n, wa;
        n = 1 + int'($urandom % 4);
        wa = int'($urandom % NR);
        for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
        do_write(wa, n);
        check_outputs("R3 R4 random multi-byte write");
      end else begin
        do_read(int'($urandom % NR), bit'($urandom % 2), 1 + int'($urandom % 4));
      end
    end

    done = 1;
    summary();
    $finish;
  end
endmodule